// File: doc/BRIEF.md
# Partitioned 8x16 rounding multiplier

This block is a small SIMD multiply unit for pixel-style arithmetic. Each lane multiplies an unsigned 8-bit value by a signed 16-bit value. It keeps the middle 16 bits of the product and rounds them half-up. A 3-bit mode selects three things: which bytes of the first operand feed the lanes, which 16-bit values of the second operand multiply them, and where the lane results land in the 64-bit output.

Callers present a mode and two 64-bit operands together with `in_valid`. One clock later `out_valid` rises and `result` holds the packed lanes. With the default parameters there are four lanes.

Top module: `pmul8x16`

## Requirements
- R1: Each lane forms the signed product of an unsigned 8-bit factor and a signed 16-bit factor. The lane result is product bits 23:8 plus one when product bit 7 is set.
- R2: The round increment wraps inside 16 bits. For example, factor 1 times -128 (0xFF80) yields 0x0000.
- R3: Mode 0 (plain): lane i multiplies `a[8i+7:8i]` by `b[16i+15:16i]` for i = 0..3. The lane result goes to `result[16i+15:16i]`.
- R4: Mode 1 broadcasts `b[31:16]` and mode 2 broadcasts `b[15:0]` as the 16-bit factor of all four lanes. Lane i takes its byte from `a[8i+7:8i]`, and the results are packed as in R3.
- R5: Mode 3 takes lane i's byte from `a[16i+15:16i+8]` and mode 4 takes it from `a[16i+7:16i]`. The 16-bit factor is `b[16i+15:16i]`, and the results are packed as in R3.
- R6: Modes 5 and 6 compute only lanes 0 and 1. Mode 5 takes the upper byte and mode 6 the lower byte, both as in R5. Lane j's result goes to `result[32j+22:32j+7]`, and every other result bit is zero.
- R7: Mode 7 is reserved and produces an all-zero result.
- R8: An accepted request appears on `result` one clock later, with `out_valid` high. `out_valid` is low in any cycle after a clock edge at which `in_valid` was low.
- R9: While `in_valid` is low, `result` holds its last value and no operand or mode change affects it.
- R10: Reset drives `out_valid` low and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Operation select (encodings in R3 to R7) |
| a | input | 64 | Unsigned byte operand |
| b | input | 64 | Signed 16-bit operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered packed lane results |

## Verification
Every byte value, 0 to 255, is swept against extreme 16-bit factors (0, ±1, -128, -129, 255, 32767, -32768) in all eight modes, and random operands are added on top. A design that took the wrong 16 bits of the product, or rounded on the wrong bit, would be off on almost every nonzero product. A design that sign-extended the byte would fail for bytes above 127. Mixing up the upper and lower byte selectors or broadcast halves would show as swapped lane values. The double-width modes are checked for the 7-bit offset and for zero bits everywhere else. The -128 case checks that the rounding carry wraps to zero. Idle cycles with changed operands check that the output register holds.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
   typedef enum logic [2:0] {
      PM_PLAIN  = 3'd0,
      PM_BC_HI  = 3'd1,
      PM_BC_LO  = 3'd2,
      PM_SEL_HI = 3'd3,
      PM_SEL_LO = 3'd4,
      PM_DBL_HI = 3'd5,
      PM_DBL_LO = 3'd6,
      PM_RSVD   = 3'd7
   } pmul_mode_e;
endpackage

// File: rtl/pmul_lane.sv
// One lane: unsigned U_W-bit factor times signed S_W-bit factor,
// keeps the S_W bits just above the low U_W bits, rounded half-up.
module pmul_lane #(
   parameter int U_W = 8,
   parameter int S_W = 16
) (
   input  logic [U_W-1:0] u_in,
   input  logic [S_W-1:0] s_in,
   output logic [S_W-1:0] q_out
);
   localparam int P_W = U_W + S_W;

   logic [P_W-1:0] u_ext;
   logic [P_W-1:0] s_ext;
   logic [S_W:0]   top_bits;

   assign u_ext    = {{S_W{1'b0}}, u_in};
   assign s_ext    = {{U_W{s_in[S_W-1]}}, s_in};
   // product modulo 2^P_W, shifted so bit 0 is the rounding bit
   assign top_bits = (S_W+1)'((u_ext * s_ext) >> (U_W - 1));
   assign q_out    = top_bits[S_W:1] + S_W'(top_bits[0]);
endmodule

// File: rtl/pmul_route.sv
// Operand steering: picks each lane's byte and 16-bit factor by mode.
module pmul_route
   import pmul_pkg::*;
#(
   parameter int LANE_N = 4,
   parameter int U_W    = 8,
   parameter int S_W    = 16,
   localparam int DATA_W = LANE_N * S_W
) (
   input  pmul_mode_e              mode,
   input  logic [DATA_W-1:0]       a,
   input  logic [DATA_W-1:0]       b,
   output logic [LANE_N*U_W-1:0]   u_flat,
   output logic [LANE_N*S_W-1:0]   s_flat
);
   for (genvar i = 0; i < LANE_N; i++) begin : g_lane
      always_comb begin
         unique case (mode)
            PM_PLAIN, PM_BC_HI, PM_BC_LO: u_flat[i*U_W +: U_W] = a[i*U_W +: U_W];
            PM_SEL_HI, PM_DBL_HI:         u_flat[i*U_W +: U_W] = a[i*S_W + U_W +: U_W];
            PM_SEL_LO, PM_DBL_LO:         u_flat[i*U_W +: U_W] = a[i*S_W +: U_W];
            default:                      u_flat[i*U_W +: U_W] = '0;
         endcase
         unique case (mode)
            PM_BC_HI: s_flat[i*S_W +: S_W] = b[S_W +: S_W];
            PM_BC_LO: s_flat[i*S_W +: S_W] = b[0 +: S_W];
            PM_RSVD:  s_flat[i*S_W +: S_W] = '0;
            default:  s_flat[i*S_W +: S_W] = b[i*S_W +: S_W];
         endcase
      end
   end
endmodule

// File: rtl/pmul_place.sv
// Result packing: dense lanes, or half the lanes on double-width slots.
module pmul_place
   import pmul_pkg::*;
#(
   parameter int LANE_N = 4,
   parameter int U_W    = 8,
   parameter int S_W    = 16,
   localparam int DATA_W = LANE_N * S_W,
   localparam int HALF_N = LANE_N / 2,
   localparam int SLOT_W = 2 * S_W,
   localparam int OFFS   = U_W - 1
) (
   input  pmul_mode_e          mode,
   input  logic [DATA_W-1:0]   q_flat,
   output logic [DATA_W-1:0]   packed_o
);
   always_comb begin
      packed_o = '0;
      unique case (mode)
         PM_DBL_HI, PM_DBL_LO: begin
            for (int j = 0; j < HALF_N; j++)
               packed_o[j*SLOT_W + OFFS +: S_W] = q_flat[j*S_W +: S_W];
         end
         PM_RSVD: packed_o = '0;
         default: packed_o = q_flat;
      endcase
   end
endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
   import pmul_pkg::*;
#(
   parameter int LANE_N = 4,
   parameter int U_W    = 8,
   parameter int S_W    = 16,
   localparam int DATA_W = LANE_N * S_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        mode,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   localparam int SLOT_W = 2 * S_W;

   if (S_W != 2 * U_W) begin : g_chk_w
      $error("pmul8x16: S_W must be twice U_W");
   end
   if (LANE_N < 2 || (LANE_N % 2) != 0) begin : g_chk_n
      $error("pmul8x16: LANE_N must be even and at least 2");
   end

   function automatic logic [DATA_W-1:0] dbl_mask();
      logic [DATA_W-1:0] m = '0;
      for (int j = 0; j < LANE_N / 2; j++)
         m[j*SLOT_W + U_W - 1 +: S_W] = '1;
      return m;
   endfunction
   localparam logic [DATA_W-1:0] DBL_MASK = dbl_mask();

   pmul_mode_e               mode_e;
   logic [LANE_N*U_W-1:0]    u_flat;
   logic [LANE_N*S_W-1:0]    s_flat;
   logic [DATA_W-1:0]        q_flat;
   logic [DATA_W-1:0]        packed_w;

   assign mode_e = pmul_mode_e'(mode);

   pmul_route #(.LANE_N(LANE_N), .U_W(U_W), .S_W(S_W)) u_route (
      .mode(mode_e), .a(a), .b(b), .u_flat(u_flat), .s_flat(s_flat)
   );

   for (genvar i = 0; i < LANE_N; i++) begin : g_mul
      pmul_lane #(.U_W(U_W), .S_W(S_W)) u_lane (
         .u_in (u_flat[i*U_W +: U_W]),
         .s_in (s_flat[i*S_W +: S_W]),
         .q_out(q_flat[i*S_W +: S_W])
      );
   end

   pmul_place #(.LANE_N(LANE_N), .U_W(U_W), .S_W(S_W)) u_place (
      .mode(mode_e), .q_flat(q_flat), .packed_o(packed_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= packed_w;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)); // R9
   AST_DBL_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode == 3'd5 || mode == 3'd6)) |=> ((result & ~DBL_MASK) == '0)); // R6
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 3'd7) |=> (result == '0)); // R7
endmodule

// File: tb/tb_pmul8x16.sv
module tb_pmul8x16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [63:0] a = '0;
   logic [63:0] b = '0;
   logic        out_valid;
   logic [63:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   pmul8x16 dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .a(a), .b(b), .out_valid(out_valid), .result(result)
   );

   // Lane arithmetic from R1/R2: floor(p/256) + bit 7 of p, modulo 2^16
   function automatic logic [15:0] lane_ref(input logic [7:0] u, input logic [15:0] s);
      int p;
      int k;
      p = int'(u) * int'(shortint'(s));
      k = (p >>> 8) + ((p >>> 7) & 1);
      return 16'(k);
   endfunction

   function automatic logic [63:0] model(input int md, input logic [63:0] x, input logic [63:0] y);
      logic [63:0] r = '0;
      for (int i = 0; i < 4; i++) begin
         logic [7:0]  u;
         logic [15:0] s;
         s = y[16*i +: 16];
         case (md)
            0: u = x[8*i +: 8];
            1: begin u = x[8*i +: 8]; s = y[31:16]; end
            2: begin u = x[8*i +: 8]; s = y[15:0]; end
            3, 5: u = x[16*i+8 +: 8];
            default: u = x[16*i +: 8];
         endcase
         if (md <= 4) r[16*i +: 16] = lane_ref(u, s);
         else if (md <= 6 && i < 2) r[32*i+7 +: 16] = lane_ref(u, s);
      end
      return r;
   endfunction

   function automatic string tag_of(input int md);
      case (md)
         0: return "R1 R3";
         1, 2: return "R1 R4";
         3, 4: return "R1 R5";
         5, 6: return "R1 R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a negedge; drives one request and checks it at the next negedge
   task automatic apply(input int md, input logic [63:0] x, input logic [63:0] y);
      in_valid = 1'b1; mode = 3'(md); a = x; b = y;
      @(negedge clk);
      check("R8 valid", 64'(out_valid), 64'd1);
      check(tag_of(md), result, model(md, x, y));
   endtask

   function automatic logic [63:0] rep16(input logic [15:0] v);
      return {v, v, v, v};
   endfunction

   initial begin
      logic [15:0] ext [8];
      logic [63:0] prev;
      ext[0] = 16'h0000; ext[1] = 16'h0001; ext[2] = 16'hFFFF; ext[3] = 16'hFF80;
      ext[4] = 16'hFF7F; ext[5] = 16'h00FF; ext[6] = 16'h7FFF; ext[7] = 16'h8000;

      repeat (3) @(negedge clk);
      check("R10 valid", 64'(out_valid), 64'd0);
      check("R10 result", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: 1 * -128 rounds up from 0xFFFF and wraps to zero
      apply(0, 64'h0000_0000_0101_0101, rep16(16'hFF80));
      check("R2 wrap", result, 64'd0);

      // sweep every byte against every extreme factor in all modes
      for (int md = 0; md < 8; md++)
         for (int e = 0; e < 8; e++)
            for (int v = 0; v < 256; v++) begin
               logic [7:0] bv;
               logic [63:0] y;
               bv = 8'(v);
               y = {ext[e], ext[(e+3)%8], ext[(e+5)%8], ext[(e+1)%8]};
               apply(md, {bv, ~bv, bv, 8'(v*7), bv, 8'hFF, 8'h00, bv}, y);
            end

      // random operands per mode
      for (int md = 0; md < 8; md++)
         for (int k = 0; k < 300; k++)
            apply(md, {$urandom, $urandom}, {$urandom, $urandom});

      // R9: idle cycles leave result unchanged despite new operands
      apply(0, 64'h1234_5678_9ABC_DEF0, 64'h7FFF_8000_0001_FFFF);
      prev = result;
      for (int k = 0; k < 4; k++) begin
         in_valid = 1'b0; mode = 3'(k); a = {$urandom, $urandom}; b = {$urandom, $urandom};
         @(negedge clk);
         check("R8 idle valid", 64'(out_valid), 64'd0);
         check("R9 hold", result, prev);
      end

      // R10: reset in mid-run clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 valid after reset", 64'(out_valid), 64'd0);
      check("R10 result after reset", result, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      apply(3, 64'hFF00_0100_8000_7F00, rep16(16'h8000));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule